// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a multiplierless FIR filter with a small, fixed number of taps. It keeps the most recent input samples in a delay line. It forms each output by walking through the bit positions of those samples, one position per clock cycle. In each cycle it takes the bit at the current position from every stored sample and uses these bits as an address into a small table. Each table entry holds the precomputed sum of the coefficients whose address bit is set. The entry read from the table is added into an accumulator that shifts right by one place each cycle. The sign-bit position is handled last, and its table value is subtracted rather than added.

Samples arrive as a valid-qualified two's complement stream. While a result is being computed, the block lowers its ready output and ignores any sample offered. When the last bit position has been processed, the block raises a one-cycle done strobe, and the signed result stays on the output until the next sample is accepted. The coefficients are parameters, and the table is built from them at elaboration.

Top module: `dafir_top`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` is 0, `in_ready` is 1 and `out_result` is 0.
- R2: A sample is taken only on a clock edge where both `in_valid` and `in_ready` are 1. After that edge, `in_ready` is 0 until the result for that sample has been produced, and it is 1 again in the cycle in which `out_valid` is 1.
- R3: `out_valid` is 1 for exactly one cycle. That cycle starts DW clock edges after the edge that took the sample, one edge per input bit position.
- R4: The result equals sum over k of c[k]*x[k]. Here x[0] is the sample just taken, and x[k] is the k-th earlier sample taken. Samples that have not been taken since reset count as 0.
- R5: Both inputs and coefficients are treated as two's complement, with the sign-bit slice weighted negatively. Results are exact for the extreme inputs -128 and 127, including a coefficient of -128.
- R6: A sample offered while `in_ready` is 0 does not enter the delay line and has no effect on any later result.
- R7: `out_result` keeps its value from the done strobe until the next sample is taken.
- R8: Table address bit k selects coefficient k, which is applied to the sample that is k places old. With the default coefficients (c0=7, c1=-128, c2=45), an impulse of 1 followed by two zeros yields the results 7, -128 and 45 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_sample | input | DW | Two's complement input sample |
| in_ready | output | 1 | Block is idle and will take a sample |
| out_valid | output | 1 | One-cycle strobe: result is ready |
| out_result | output | DW+CW+clog2(TAPS) | Two's complement filter result |

## Verification
The assertions check on every cycle the handshake and timing rules. They confirm that ready falls after each accepted sample, that the done strobe lasts a single cycle and arrives exactly DW edges after acceptance, and that the result is held while the block sits idle. Arithmetic correctness cannot be seen by a property. It shows only in the bench's scenarios, which compare each result against a direct multiply-accumulate model. These scenarios cover an impulse that exposes the tap-to-address order, pseudo-random streams, runs of extreme values that exercise the subtracted sign slice, and samples offered during a computation that must leave later results untouched.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    // Controller phase
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // Command from the controller to the accumulator
    typedef struct packed {
        logic clear;   // start of a new result
        logic step;    // accumulate one bit slice
        logic last;    // current slice is the sign slice
    } acc_cmd_t;

    // Log2 with a floor of one bit
    function automatic int unsigned lg(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Width of one table entry: sum of TAPS coefficients
    function automatic int unsigned tbl_width(input int unsigned cw, input int unsigned taps);
        return cw + lg(taps);
    endfunction

    // Width of the full result
    function automatic int unsigned acc_width(input int unsigned dw, input int unsigned cw,
                                              input int unsigned taps);
        return dw + cw + lg(taps);
    endfunction

endpackage

// File: rtl/dafir_delay.sv
module dafir_delay #(
    parameter int TAPS = 3,
    parameter int DW   = 8,
    localparam int SW  = dafir_pkg::lg(DW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic [DW-1:0]   din,
    input  logic [SW-1:0]   bit_sel,
    output logic [TAPS-1:0] slice
);
    // tap 0 is the newest sample
    logic [DW-1:0] tap_q [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)           tap_q[k] <= '0;
                else if (shift_en) tap_q[k] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)           tap_q[k] <= '0;
                else if (shift_en) tap_q[k] <= tap_q[k-1];
            end
        end
        assign slice[k] = tap_q[k][bit_sel];
    end

endmodule

// File: rtl/dafir_lut.sv
module dafir_lut #(
    parameter int TAPS = 3,
    parameter int CW   = 8,
    parameter logic [TAPS*CW-1:0] COEFS = '0,
    localparam int TW  = dafir_pkg::tbl_width(CW, TAPS),
    localparam int NE  = 1 << TAPS
) (
    input  logic [TAPS-1:0]        addr,
    output logic signed [TW-1:0]   entry
);
    // Sum of the coefficients selected by the set bits of an address
    function automatic logic signed [TW-1:0] subset_sum(input int a);
        logic signed [TW-1:0] acc;
        logic [CW-1:0]        c;
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            c = COEFS[k*CW +: CW];
            if (((a >> k) & 1) == 1)
                acc = acc + {{(TW-CW){c[CW-1]}}, c};
        end
        return acc;
    endfunction

    logic signed [TW-1:0] tbl [NE];

    for (genvar a = 0; a < NE; a++) begin : g_entry
        assign tbl[a] = subset_sum(a);
    end

    assign entry = tbl[addr];

endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl #(
    parameter int DW  = 8,
    localparam int SW = dafir_pkg::lg(DW)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 shift_en,
    output logic [SW-1:0]        bit_sel,
    output dafir_pkg::acc_cmd_t  cmd,
    output logic                 out_valid
);
    import dafir_pkg::*;

    run_state_t    state_q;
    logic [SW-1:0] cnt_q;
    logic          accept;

    assign in_ready  = (state_q == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign shift_en  = accept;
    assign bit_sel   = cnt_q;
    assign cmd.clear = accept;
    assign cmd.step  = (state_q == ST_RUN);
    assign cmd.last  = (state_q == ST_RUN) && (cnt_q == SW'(DW-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= cmd.last;
            if (accept) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
            end else if (state_q == ST_RUN) begin
                if (cmd.last) begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dafir_accum.sv
module dafir_accum #(
    parameter int DW = 8,
    parameter int TW = 10,
    localparam int AW = DW + TW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  dafir_pkg::acc_cmd_t  cmd,
    input  logic signed [TW-1:0] term,
    output logic signed [AW-1:0] result
);
    // hi_q holds the upper part and lo_q collects bits shifted out at the bottom
    logic signed [TW-1:0] hi_q;
    logic [DW-1:0]        lo_q;
    logic signed [TW:0]   ext;
    logic signed [TW:0]   addend;
    logic signed [TW:0]   sum;

    assign ext    = {term[TW-1], term};
    assign addend = cmd.last ? -ext : ext;   // sign slice carries negative weight
    assign sum    = {hi_q[TW-1], hi_q} + addend;

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (cmd.step) begin
            hi_q <= sum[TW:1];
            lo_q <= {sum[0], lo_q[DW-1:1]};
        end
    end

    assign result = {hi_q, lo_q};

endmodule

// File: rtl/dafir_top.sv
module dafir_top #(
    parameter int TAPS = 3,
    parameter int DW   = 8,
    parameter int CW   = 8,
    parameter logic [TAPS*CW-1:0] COEFS = {8'sd45, -8'sd128, 8'sd7},
    localparam int AW  = dafir_pkg::acc_width(DW, CW, TAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    output logic          in_ready,
    output logic          out_valid,
    output logic [AW-1:0] out_result
);
    localparam int SW = dafir_pkg::lg(DW);
    localparam int TW = dafir_pkg::tbl_width(CW, TAPS);

    logic                 shift_en;
    logic [SW-1:0]        bit_sel;
    logic [TAPS-1:0]      slice;
    logic signed [TW-1:0] term;
    logic signed [AW-1:0] result;
    dafir_pkg::acc_cmd_t  cmd;

    dafir_ctrl #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .shift_en (shift_en),
        .bit_sel  (bit_sel),
        .cmd      (cmd),
        .out_valid(out_valid)
    );

    dafir_delay #(.TAPS(TAPS), .DW(DW)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .shift_en(shift_en),
        .din     (in_sample),
        .bit_sel (bit_sel),
        .slice   (slice)
    );

    dafir_lut #(.TAPS(TAPS), .CW(CW), .COEFS(COEFS)) u_lut (
        .addr (slice),
        .entry(term)
    );

    dafir_accum #(.DW(DW), .TW(TW)) u_accum (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .term  (term),
        .result(result)
    );

    assign out_result = result;

endmodule

// File: rtl/dafir_checker.sv
module dafir_checker #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic [AW-1:0] out_result
);
    localparam int CKW = dafir_pkg::lg(DW + 2) + 1;

    // Cycles since the accepting edge, counted independently of the design
    logic [CKW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)                                     since_q <= '0;
        else if (in_valid && in_ready)               since_q <= CKW'(1);
        else if (since_q != '0 && since_q <= CKW'(DW)) since_q <= since_q + 1'b1;
        else                                         since_q <= '0;
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_ready_on_done_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (since_q == CKW'(DW + 1)));

    assert_done_not_missed_R3: assert property (@(posedge clk) disable iff (rst)
        (since_q == CKW'(DW + 1)) |-> out_valid);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> $stable(out_result));

endmodule

bind dafir_top dafir_checker #(.DW(DW), .AW(AW)) u_dafir_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_result(out_result)
);

// File: tb/test_dafir_top.sv
module test_dafir_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int AW         = 18;
    localparam int WATCHDOG   = 20000;

    // coefficients of the default configuration, tap 0 first
    int coef [3] = '{7, -128, 45};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          in_ready;
    logic          out_valid;
    logic [AW-1:0] out_result;

    always #(CLK_PERIOD/2) clk = ~clk;

    dafir_top i_dafir_top (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_result(out_result)
    );

    typedef struct {
        int    value;
        int    acc_cyc;
        string tag;
    } exp_t;

    exp_t sb [$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   hist [3] = '{0, 0, 0};
    int   seed   = 32'h1234;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // driver: offer a sample, model it, push the expected result
    task automatic send(input int s, input string tag);
        int e;
        exp_t it;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_sample = s[DW-1:0];
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = s;
        e = 0;
        for (int k = 0; k < 3; k++) e += coef[k] * hist[k];
        @(negedge clk);
        it.value = e;
        it.acc_cyc = cyc;
        it.tag = tag;
        sb.push_back(it);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R2 ready after accept", int'(in_ready), 0);
    endtask

    // offer junk while busy; none of it may be taken (R6)
    task automatic poke_busy(input int n);
        for (int i = 0; i < n; i++) begin
            check(in_ready == 1'b0, "R6 busy while poked", int'(in_ready), 0);
            in_valid  = 1'b1;
            in_sample = 8'h55;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(int'($signed(out_result)) == it.value, it.tag,
                      int'($signed(out_result)), it.value);
                check(cyc - it.acc_cyc == DW, "R3 latency", cyc - it.acc_cyc, DW);
                check(in_ready == 1'b1, "R2 ready at done", int'(in_ready), 1);
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", cyc, WATCHDOG);
        finish_run();
    end

    initial begin
        int held;
        int s;
        repeat (3) @(negedge clk);
        // R1: values during reset
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        check(out_result == '0, "R1 result in reset", int'(out_result), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // R8: impulse exposes tap-to-address order
        send(1, "R8 impulse tap0");
        send(0, "R8 impulse tap1");
        send(0, "R8 impulse tap2");

        // R7: result holds while idle
        wait (sb.size() == 0);
        @(negedge clk);
        held = int'($signed(out_result));
        repeat (6) @(negedge clk);
        check(int'($signed(out_result)) == held, "R7 hold", int'($signed(out_result)), held);

        // R4: pseudo-random stream
        for (int i = 0; i < 30; i++) begin
            seed = seed * 1103515245 + 12345;
            s = (seed >>> 16) & 255;
            if (s > 127) s -= 256;
            send(s, "R4 random");
        end

        // R5: extreme values and the sign slice
        for (int i = 0; i < 4; i++) send(-128, "R5 min run");
        for (int i = 0; i < 3; i++) send(127, "R5 max run");
        for (int i = 0; i < 4; i++) begin
            send(-128, "R5 alternate");
            send(127, "R5 alternate");
        end

        // R6: samples offered while busy are ignored
        send(10, "R6 before poke");
        poke_busy(3);
        send(-20, "R6 after poke");
        poke_busy(5);
        send(3, "R6 after poke");
        send(0, "R6 flush");

        wait (sb.size() == 0);
        repeat (DW + 4) @(negedge clk);
        check(sb.size() == 0, "R3 all results seen", sb.size(), 0);
        finish_run();
    end

endmodule